// File: doc/BRIEF.md
# Interprocessor Doorbell Mailbox

This block lets one processor ring doorbells on another through three independent channels, indexed in a fixed order: 0 is the low-priority non-secure channel, 1 is the high-priority non-secure channel and 2 is the secure channel. Each channel keeps a 32-bit pending word. Every bit of that word is a separate doorbell, so several different event types can wait on one channel together. A sender rings doorbells by writing ones to the channel's set register. The receiver acknowledges them by writing ones to the clear register. Because both registers act only on the bits written as one, neither side needs a read-modify-write. The OR of a channel's pending word, taken through a register, drives that channel's interrupt line.

Access is through an APB-style slave port. Each access carries a non-secure attribute. A non-secure access to the secure channel is filtered: it reads as zero, its writes do nothing, and it gets a slave error. A small bus state machine with two named states tracks the protocol. BUS_IDLE goes to BUS_ARMED on a setup phase (psel high, penable low). BUS_ARMED stays in BUS_ARMED on another setup phase. It returns to BUS_IDLE when an access phase completes or psel drops. Only an access phase that follows a setup phase commits.

Top module: `dbell_mbox`

## Requirements
- R1: A synchronous active-low reset clears all three pending words and drives all three interrupt outputs to 0.
- R2: A committed write to a channel's set register (channel base + 0x08) ORs pwdata into the pending word. Bits written as 0 keep their value.
- R3: A committed write to a channel's clear register (channel base + 0x10) clears the pending bits that are 1 in pwdata. Bits written as 0 keep their value.
- R4: A read of a channel's status register (channel base + 0x00) returns the whole pending word, so several pending doorbells are visible at once.
- R5: irq[i] goes to 1 one clock after channel i's pending word becomes nonzero. It goes to 0 one clock after the word returns to zero.
- R6: Channel bases are 0x000 for index 0, 0x020 for index 1 and 0x200 for index 2. irq bit i belongs to channel i, and activity on one channel leaves the other channels' words and lines unchanged.
- R7: When ns_access=1 and the access targets a register of channel 2, the read returns 0, a write has no effect, and pslverr is 1 during that access phase. A secure access (ns_access=0) to channel 2 works normally with pslverr 0.
- R8: Reads of unmapped addresses, and reads of the write-only set and clear offsets, return 0 with pslverr 0. Writes to unmapped addresses and to status offsets change nothing.
- R9: A transfer commits only in an access phase (psel=1, penable=1) whose previous cycle was a setup phase (psel=1, penable=0). pready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| ns_access | input | 1 | 1 = non-secure access |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error for a filtered secure access |
| irq | output | 3 | One interrupt per channel, index order 0..2 |

## Verification
The bench tests set and clear with single-bit, multi-bit and overlapping masks. This shows whether zero bits really leave the pending word alone and whether partial clears keep the interrupt high. It repeats the same operations on each channel base, which exposes decode or channel-swap faults in the interrupt index. Secure and non-secure accesses to the secure channel show that the filter works and what error it reports. Unmapped offsets, status-offset writes and an access phase with no setup phase check that stray traffic changes nothing. A behavioural model predicts the three interrupt lines every clock, so the one-cycle rise and fall are checked against the model in every clock.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    localparam int NCH  = 3;
    localparam int CH_W = $clog2(NCH);

    typedef enum logic {
        BUS_IDLE,
        BUS_ARMED
    } bus_st_e;

    typedef enum logic [1:0] {
        RK_STATUS,
        RK_SET,
        RK_CLEAR,
        RK_NONE
    } reg_kind_e;
endpackage

// File: rtl/dbell_apb_fsm.sv
module dbell_apb_fsm
    import dbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic commit
);
    bus_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = BUS_IDLE;
        unique case (st_q)
            BUS_IDLE:  st_d = (psel && !penable) ? BUS_ARMED : BUS_IDLE;
            BUS_ARMED: st_d = (psel && !penable) ? BUS_ARMED : BUS_IDLE;
            default:   st_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (st_q)
            BUS_IDLE:  commit = 1'b0;
            BUS_ARMED: commit = psel && penable;
            default:   commit = 1'b0;
        endcase
    end

    // R9: a commit needs a setup phase on the previous clock
    p_commit_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(psel && !penable));
endmodule

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int AW       = 12,
    parameter int WIN      = 'h20,
    parameter int BASE_LP  = 'h000,
    parameter int BASE_HP  = 'h020,
    parameter int BASE_SEC = 'h200,
    parameter int OFF_STAT = 'h00,
    parameter int OFF_SET  = 'h08,
    parameter int OFF_CLR  = 'h10,
    parameter int SEC_IDX  = 2
) (
    input  logic [AW-1:0]   addr,
    input  logic            ns,
    output logic            hit,
    output logic [CH_W-1:0] ch,
    output reg_kind_e       kind,
    output logic            blocked
);
    localparam logic [AW-1:0] WMASK = AW'(WIN - 1);
    localparam logic [AW-1:0] BASES [NCH] = '{AW'(BASE_LP), AW'(BASE_HP), AW'(BASE_SEC)};

    logic [AW-1:0] off;
    logic          win_hit;

    always_comb begin
        off = addr & WMASK;
        if (off == AW'(OFF_STAT))     kind = RK_STATUS;
        else if (off == AW'(OFF_SET)) kind = RK_SET;
        else if (off == AW'(OFF_CLR)) kind = RK_CLEAR;
        else                          kind = RK_NONE;
    end

    always_comb begin
        win_hit = 1'b0;
        ch      = '0;
        for (int i = 0; i < NCH; i++) begin
            if ((addr & ~WMASK) == BASES[i]) begin
                win_hit = 1'b1;
                ch      = CH_W'(i);
            end
        end
    end

    assign hit     = win_hit && (kind != RK_NONE);
    assign blocked = hit && ns && (ch == CH_W'(SEC_IDX));
endmodule

// File: rtl/dbell_chan.sv
module dbell_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_stb,
    input  logic [DW-1:0] set_val,
    input  logic          clr_stb,
    input  logic [DW-1:0] clr_val,
    output logic [DW-1:0] status_o,
    output logic          irq_o
);
    logic [DW-1:0] stat_q, stat_d;
    logic          irq_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_stb) stat_d = stat_d & ~clr_val;
        if (set_stb) stat_d = stat_d | set_val;   // set has priority on overlap
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= |stat_q;
        end
    end

    assign status_o = stat_q;
    assign irq_o    = irq_q;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && !irq_o));
    // R2
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((status_o & $past(set_val)) == $past(set_val)));
    // R3
    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> ((status_o & $past(clr_val)) == '0));
    // R2, R3: no strobe, no change
    p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(status_o));
    // R5
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && (|set_val)) |=> ##1 irq_o);
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
    import dbell_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int WIN      = 'h20,
    parameter int BASE_LP  = 'h000,
    parameter int BASE_HP  = 'h020,
    parameter int BASE_SEC = 'h200,
    parameter int OFF_STAT = 'h00,
    parameter int OFF_SET  = 'h08,
    parameter int OFF_CLR  = 'h10,
    parameter int SEC_IDX  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic           ns_access,
    input  logic [AW-1:0]  paddr,
    input  logic [DW-1:0]  pwdata,
    output logic [DW-1:0]  prdata,
    output logic           pready,
    output logic           pslverr,
    output logic [NCH-1:0] irq
);
    logic            commit;
    logic            hit;
    logic [CH_W-1:0] ch;
    reg_kind_e       kind;
    logic            blocked;
    logic [DW-1:0]   st_arr [NCH];
    logic [DW-1:0]   sel_stat;

    dbell_apb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .commit  (commit)
    );

    dbell_decode #(
        .AW(AW), .WIN(WIN), .BASE_LP(BASE_LP), .BASE_HP(BASE_HP),
        .BASE_SEC(BASE_SEC), .OFF_STAT(OFF_STAT), .OFF_SET(OFF_SET),
        .OFF_CLR(OFF_CLR), .SEC_IDX(SEC_IDX)
    ) u_dec (
        .addr    (paddr),
        .ns      (ns_access),
        .hit     (hit),
        .ch      (ch),
        .kind    (kind),
        .blocked (blocked)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic wr_ok;
        assign wr_ok = commit && pwrite && hit && !blocked && (ch == CH_W'(g));

        dbell_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_stb  (wr_ok && (kind == RK_SET)),
            .set_val  (pwdata),
            .clr_stb  (wr_ok && (kind == RK_CLEAR)),
            .clr_val  (pwdata),
            .status_o (st_arr[g]),
            .irq_o    (irq[g])
        );
    end

    always_comb begin
        sel_stat = '0;
        for (int i = 0; i < NCH; i++)
            if (ch == CH_W'(i)) sel_stat = st_arr[i];
    end

    assign prdata  = (commit && !pwrite && hit && !blocked && kind == RK_STATUS) ? sel_stat : '0;
    assign pslverr = commit && blocked;
    assign pready  = 1'b1;

    // R7: an errored access never returns data
    p_err_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (prdata == '0));
    // R7: a filtered access leaves the secure word alone
    p_ns_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && blocked) |=> $stable(st_arr[SEC_IDX]));
endmodule

// File: tb/sim_dbell_mbox.sv
module sim_dbell_mbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, ns_access = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [2:0]  irq;

    int nchk = 0;
    int nerr = 0;
    bit run  = 1'b0;

    logic [31:0] m_stat [3] = '{32'h0, 32'h0, 32'h0};
    logic [2:0]  m_irq   = '0;
    logic        m_armed = 1'b0;

    always #5 clk = ~clk;

    dbell_mbox u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .ns_access(ns_access), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq(irq)
    );

    // returns channel index or -1, and kind: 0 status, 1 set, 2 clear, 3 none
    function automatic int m_chan(input logic [11:0] a);
        case (a & 12'hFE0)
            12'h000: return 0;
            12'h020: return 1;
            12'h200: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic int m_kind(input logic [11:0] a);
        case (a & 12'h01F)
            12'h000: return 0;
            12'h008: return 1;
            12'h010: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic bit m_blocked(input logic [11:0] a, input logic ns);
        return ns && m_chan(a) == 2 && m_kind(a) != 3;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a, input logic ns);
        int c = m_chan(a);
        if (c < 0 || m_kind(a) != 0 || m_blocked(a, ns)) return 32'h0;
        return m_stat[c];
    endfunction

    // behavioural reference, updated on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_stat[i] <= 32'h0;
            m_irq   <= '0;
            m_armed <= 1'b0;
        end else begin
            for (int i = 0; i < 3; i++) m_irq[i] <= (m_stat[i] != 32'h0);
            m_armed <= psel && !penable;
            if (m_armed && psel && penable && pwrite) begin
                int c;
                c = m_chan(paddr);
                if (c >= 0 && !m_blocked(paddr, ns_access)) begin
                    if (m_kind(paddr) == 1) m_stat[c] <= m_stat[c] | pwdata;
                    else if (m_kind(paddr) == 2) m_stat[c] <= m_stat[c] & ~pwdata;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R5: interrupt lines against the model on every clock
    always @(negedge clk) if (run) chk("R5 irq per cycle", {29'h0, irq}, {29'h0, m_irq});

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input logic ns, input string tag);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; ns_access = ns;
        @(negedge clk);
        penable = 1;
        #1;
        chk({tag, " pslverr"}, {31'h0, pslverr}, {31'h0, m_blocked(a, ns)});
        chk("R9 pready", {31'h0, pready}, 32'h1);
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, input logic ns, input string tag);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a; ns_access = ns;
        @(negedge clk);
        penable = 1;
        #1;
        chk({tag, " prdata"}, prdata, m_read(a, ns));
        chk({tag, " pslverr"}, {31'h0, pslverr}, {31'h0, m_blocked(a, ns)});
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run = 1'b1;
        chk("R1 irq in reset", {29'h0, irq}, 32'h0);
        rst_n = 1'b1;
        apb_rd(12'h000, 0, "R1 ch0 after reset");
        apb_rd(12'h200, 0, "R1 ch2 after reset");

        // R2 / R5 timing: write leaves us one clock past the commit edge
        apb_wr(12'h008, 32'h0000_0011, 0, "R2 set ch0");
        chk("R5 irq0 not yet", {31'h0, irq[0]}, 32'h0);
        @(negedge clk);
        chk("R5 irq0 one clock later", {31'h0, irq[0]}, 32'h1);
        apb_rd(12'h000, 0, "R2 read ch0");
        apb_wr(12'h008, 32'h0000_0100, 0, "R2 set more");
        apb_rd(12'h000, 0, "R4 multiple pending");
        chk("R4 value", m_stat[0], 32'h0000_0111);

        // R3
        apb_wr(12'h010, 32'h0000_0001, 0, "R3 clear one");
        apb_rd(12'h000, 0, "R3 partial clear");
        chk("R3 irq stays", {31'h0, irq[0]}, 32'h1);
        apb_wr(12'h010, 32'h0000_0110, 0, "R3 clear rest");
        chk("R5 irq0 held one clock", {31'h0, irq[0]}, 32'h1);
        @(negedge clk);
        chk("R5 irq0 fell", {31'h0, irq[0]}, 32'h0);

        // R6
        apb_wr(12'h028, 32'h8000_0000, 0, "R6 set ch1");
        @(negedge clk);
        chk("R6 only irq1", {29'h0, irq}, 32'h2);
        apb_rd(12'h020, 0, "R6 read ch1");
        apb_rd(12'h000, 0, "R6 ch0 untouched");

        // R7
        apb_wr(12'h208, 32'h0000_00FF, 1, "R7 ns set ch2");
        apb_rd(12'h200, 0, "R7 ch2 still clear");
        apb_wr(12'h208, 32'h0000_00A5, 0, "R7 secure set ch2");
        apb_rd(12'h200, 0, "R7 secure read");
        apb_rd(12'h200, 1, "R7 ns read");
        apb_wr(12'h210, 32'hFFFF_FFFF, 1, "R7 ns clear ch2");
        apb_rd(12'h200, 0, "R7 clear ignored");
        chk("R7 word kept", m_stat[2], 32'h0000_00A5);

        // R8
        apb_rd(12'h004, 0, "R8 unmapped offset");
        apb_rd(12'h040, 0, "R8 unmapped window");
        apb_rd(12'h008, 0, "R8 set reads zero");
        apb_rd(12'h210, 1, "R8 ns clear offset read");
        apb_wr(12'h048, 32'hFFFF_FFFF, 0, "R8 unmapped write");
        apb_wr(12'h020, 32'h0000_0001, 0, "R8 status write");
        apb_rd(12'h020, 0, "R8 ch1 unchanged");
        apb_rd(12'h000, 0, "R8 ch0 unchanged");

        // R9: access phase with no setup phase
        @(negedge clk);
        psel = 1; penable = 1; pwrite = 1; paddr = 12'h008; pwdata = 32'h0000_0F00; ns_access = 0;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        apb_rd(12'h000, 0, "R9 bare access ignored");
        chk("R9 model word", m_stat[0], 32'h0);

        // R1 mid-run reset
        apb_wr(12'h008, 32'h0000_0003, 0, "R1 preload");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 irq after reset", {29'h0, irq}, 32'h0);
        rst_n = 1'b1;
        apb_rd(12'h000, 0, "R1 ch0 cleared");
        apb_rd(12'h020, 0, "R1 ch1 cleared");
        apb_rd(12'h200, 0, "R1 ch2 cleared");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule